// File: doc/BRIEF.md
# Restartable Burst Read Master

This block is the host side of a parallel memory bus. It runs one read transfer at a time: either a single word or a four-word line burst. The core hands it a request, which carries the address and a burst flag. The master then places the address on the bus with a start strobe. It collects words on the burst-ready input and flags the final data phase with a last strobe. When every word of the request is held in its four-word read buffer, it pulses done toward the core.

Another bus owner can take the bus at any time by raising the backoff input. The master then drops its output enables and stops driving address and strobes. It discards any word returned in the clock where backoff is seen. When backoff falls, it opens a new bus cycle at the first word still missing and keeps the words it already has. A plain ready input closes the current bus cycle after one word. The master then opens a fresh cycle for whatever remains.

On the core side, the request follows valid/ready rules. The core holds `req_valid`, `req_addr` and `req_burst` steady until a clock where `req_ready` is also high, and that clock transfers the request. `req_ready` is high only while the master is idle. `done` has no back-pressure. `rd_data` stays unchanged until the next transfer writes it, so the core may read it in the `done` clock or at any later time before its next request.

Top module: `rburst_master`

## Requirements
- R1: A synchronous reset returns the master to idle. After reset, `bus_oe`, `bus_start`, `bus_last` and `done` are 0 and `req_ready` is 1, even when the reset arrives in the middle of a transfer.
- R2: A request is accepted only on a clock where `req_valid` and `req_ready` are both high, and `req_ready` is low while a transfer is in progress. In the clock after acceptance, `bus_start` and `bus_oe` are 1 and `bus_addr` carries the first word's address.
- R3: A burst takes four words in wrap order inside the 16-byte line. Word i sits at line offset ((start word + i) mod 4) in address bits [3:2], and the byte bits [1:0] of the request pass through unchanged. Each word lands in the buffer slot matching its address bits [3:2], which is `rd_data` bits [slot*32 +: 32].
- R4: A single request takes exactly one word, with `bus_last` high during its data phase. The word lands in the slot given by address bits [3:2].
- R5: Backoff seen during a data phase takes priority over `bus_brdy` and `bus_rdy` in the same clock. The word returned in that clock is discarded. From the next clock on, while backoff stays high, `bus_oe` and `bus_start` are 0.
- R6: In the clock after backoff is seen low, `bus_start` is 1 and `bus_addr` holds the address of the first word not yet accepted. Words accepted before the backoff remain in the buffer.
- R7: Backoff in the same clock as `bus_start` aborts the cycle. `bus_oe` is 0 from the next clock, and the restart begins at the same word.
- R8: `bus_last` is high during every data-phase clock of the final remaining word and at no other time. When a backoff leaves one word outstanding, the restarted cycle asserts `bus_last` in its only data phase.
- R9: `bus_rdy` accepts the current word and closes the bus cycle. If words remain, `bus_start` is 1 in the next clock with the next word's address, so the number of start strobes per transfer equals one plus the number of such breaks.
- R10: `done` is high for exactly one clock. It comes in the clock after the final word is accepted, with all requested words already in `rd_data` and `req_ready` already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core offers a read request |
| req_ready | output | 1 | Master is idle and takes a request |
| req_addr | input | 32 | Byte address of the first word |
| req_burst | input | 1 | 1: four-word line burst, 0: single word |
| done | output | 1 | One-clock pulse: request complete |
| rd_data | output | 128 | Read buffer, slot k at bits [k*32 +: 32] |
| bus_addr | output | 32 | Bus address, zero when not driven |
| bus_start | output | 1 | Address strobe, high for the first clock of a bus cycle |
| bus_last | output | 1 | High during the data phase of the final remaining word |
| bus_oe | output | 1 | Output enable for address and strobes; 0 means floated |
| bus_rdy | input | 1 | Accept word and end the bus cycle |
| bus_brdy | input | 1 | Accept word and continue the burst |
| bus_backoff | input | 1 | Another owner takes the bus |
| bus_data_in | input | 32 | Read data from the bus |

## Verification
The hardest case is a backoff that arrives in the very clock where a word is also being acknowledged, either by burst-ready or by plain ready. The bench provokes this by driving `bus_backoff` together with `bus_brdy` on a chosen word, and it places a poison pattern on the data lines in that clock. The result is judged in three ways: the poison must never appear in the buffer, the restart address must name the same word again, and the number of start strobes must match the table row. The collision of backoff with the start strobe is provoked and judged the same way, including a row where both collisions happen in one transfer.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } bus_state_e;
endpackage

// File: rtl/rbm_beat_ctr.sv
module rbm_beat_ctr #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             burst,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             final_beat
);
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      last_idx <= '0;
    end else if (load) begin
      idx      <= '0;
      last_idx <= burst ? IDX_W'(BEATS - 1) : '0;
    end else if (advance) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assign final_beat = (idx == last_idx);
endmodule

// File: rtl/rbm_addr_gen.sv
module rbm_addr_gen #(
  parameter int AW         = 32,
  parameter int BEATS      = 4,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W   = $clog2(BEATS),
  localparam int OFF_LSB = $clog2(WORD_BYTES)
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] slot,
  output logic [AW-1:0]    addr
);
  // wrap inside the line: only the word-select bits move
  assign slot = base[OFF_LSB +: IDX_W] + idx;
  assign addr = {base[AW-1:OFF_LSB+IDX_W], slot, base[OFF_LSB-1:0]};
endmodule

// File: rtl/rbm_rd_buf.sv
module rbm_rd_buf #(
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_slot,
  input  logic [DW-1:0]       wr_data,
  output logic [BEATS*DW-1:0] rd_flat
);
  for (genvar g = 0; g < BEATS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (wr_en && (wr_slot == IDX_W'(g)))
        word_q <= wr_data;
    end
    assign rd_flat[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/rburst_master.sv
module rburst_master
  import rbm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BEATS      = 4,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_burst,
  output logic                done,
  output logic [BEATS*DW-1:0] rd_data,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_start,
  output logic                bus_last,
  output logic                bus_oe,
  input  logic                bus_rdy,
  input  logic                bus_brdy,
  input  logic                bus_backoff,
  input  logic [DW-1:0]       bus_data_in
);
  bus_state_e       state;
  logic [AW-1:0]    base_q;
  logic             done_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] slot;
  logic [AW-1:0]    cur_addr;
  logic             final_beat;
  logic             take_req;
  logic             beat_ok;
  logic             advance;

  assign take_req = (state == ST_IDLE) && req_valid;
  // backoff in the same clock wins over either acknowledge
  assign beat_ok  = (state == ST_DATA) && !bus_backoff && (bus_brdy || bus_rdy);
  assign advance  = beat_ok && !final_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          base_q <= req_addr;
          state  <= ST_ADDR;
        end
        ST_ADDR: state <= bus_backoff ? ST_HOLD : ST_DATA;
        ST_DATA: begin
          if (bus_backoff) begin
            state <= ST_HOLD;
          end else if (bus_brdy || bus_rdy) begin
            if (final_beat) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else if (bus_rdy) begin
              state <= ST_ADDR;
            end
          end
        end
        ST_HOLD: if (!bus_backoff) state <= ST_ADDR;
        default: state <= ST_IDLE;
      endcase
    end
  end

  rbm_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load       (take_req),
    .burst      (req_burst),
    .advance    (advance),
    .idx        (idx),
    .final_beat (final_beat)
  );

  rbm_addr_gen #(.AW(AW), .BEATS(BEATS), .WORD_BYTES(WORD_BYTES)) u_agen (
    .base (base_q),
    .idx  (idx),
    .slot (slot),
    .addr (cur_addr)
  );

  rbm_rd_buf #(.DW(DW), .BEATS(BEATS)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (beat_ok),
    .wr_slot (slot),
    .wr_data (bus_data_in),
    .rd_flat (rd_data)
  );

  assign req_ready = (state == ST_IDLE);
  assign done      = done_q;
  assign bus_oe    = (state == ST_ADDR) || (state == ST_DATA);
  assign bus_start = (state == ST_ADDR);
  assign bus_last  = (state == ST_DATA) && final_beat;
  assign bus_addr  = bus_oe ? cur_addr : '0;
endmodule

// File: rtl/rburst_master_chk.sv
module rburst_master_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic done,
  input logic bus_start,
  input logic bus_last,
  input logic bus_oe,
  input logic bus_rdy,
  input logic bus_backoff
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!bus_oe && !done && req_ready));

  // R2
  idle_not_driving_chk: assert property (@(posedge clk) disable iff (rst) req_ready |-> !bus_oe);

  // R2
  start_enabled_chk: assert property (@(posedge clk) disable iff (rst) bus_start |-> bus_oe);

  // R5
  float_after_backoff_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_backoff && bus_oe && !bus_start) |=> (!bus_oe && !bus_start));

  // R7
  abort_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_start && bus_backoff) |=> (!bus_oe && !bus_start));

  // R6
  restart_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe && !req_ready && !bus_backoff) |=> bus_start);

  // R8
  last_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    bus_last |-> (bus_oe && !bus_start));

  // R9
  ready_reopens_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && !bus_start && bus_rdy && !bus_backoff && !bus_last) |=> bus_start);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> req_ready);
endmodule

bind rburst_master rburst_master_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .done        (done),
  .bus_start   (bus_start),
  .bus_last    (bus_last),
  .bus_oe      (bus_oe),
  .bus_rdy     (bus_rdy),
  .bus_backoff (bus_backoff)
);

// File: tb/rburst_master_test.sv
`timescale 1ns/1ps
module rburst_master_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_burst = 1'b0;
  logic         done;
  logic [127:0] rd_data;
  logic [31:0]  bus_addr;
  logic         bus_start, bus_last, bus_oe;
  logic         bus_rdy = 1'b0, bus_brdy = 1'b0, bus_backoff = 1'b0;
  logic [31:0]  bus_data_in = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rburst_master uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_burst(req_burst), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_start(bus_start), .bus_last(bus_last), .bus_oe(bus_oe),
    .bus_rdy(bus_rdy), .bus_brdy(bus_brdy), .bus_backoff(bus_backoff),
    .bus_data_in(bus_data_in)
  );

  // {addr, burst, backoff word (7 none), backoff on start, rdy word (7 none), expected starts}
  localparam logic [42:0] VEC [10] = '{
    {32'h1000_0000, 1'b1, 3'd7, 1'b0, 3'd7, 3'd1},
    {32'h1000_0048, 1'b1, 3'd2, 1'b0, 3'd7, 3'd2},
    {32'h2000_0004, 1'b0, 3'd7, 1'b0, 3'd7, 3'd1},
    {32'h2000_010C, 1'b1, 3'd7, 1'b1, 3'd7, 3'd2},
    {32'h3000_0000, 1'b1, 3'd7, 1'b0, 3'd1, 3'd2},
    {32'h3000_0024, 1'b1, 3'd3, 1'b0, 3'd7, 3'd2},
    {32'h4000_0008, 1'b0, 3'd0, 1'b0, 3'd7, 3'd2},
    {32'h4000_0031, 1'b1, 3'd0, 1'b1, 3'd7, 3'd3},
    {32'h5000_0014, 1'b1, 3'd7, 1'b0, 3'd3, 3'd1},
    {32'h5000_0038, 1'b0, 3'd7, 1'b0, 3'd0, 3'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem(input logic [31:0] a);
    return 32'h5A00_0000 ^ (a * 32'd7);
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] b, input int i);
    logic [1:0] w;
    w = b[3:2] + 2'(i);
    return {b[31:4], w, b[1:0]};
  endfunction

  task automatic run_txn(input logic [31:0] a, input bit burst, input int boffw,
                         input bit boffads, input int rdyw, input int exp_starts);
    int nb = burst ? 4 : 1;
    int got = 0, starts = 0, hold = 0, guard = 0;
    bit boff_used = 0, ads_used = 0, prev_boff = 0, prev_ads = 0, prev_rdy = 0, fin = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_burst = burst;
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin && guard < 200) begin
      guard++;
      bus_brdy = 1'b0; bus_rdy = 1'b0; bus_data_in = 32'hDEAD_BEEF;
      if (hold == 0) bus_backoff = 1'b0;
      if (prev_boff)
        chk(!bus_oe && !bus_start, prev_ads ? "R7 float after abort on start" : "R5 float after backoff",
            64'({bus_oe, bus_start}), 64'(0));
      if (prev_rdy)
        chk(bus_start, "R9 new cycle after ready", 64'(bus_start), 64'(1));
      prev_boff = 0; prev_ads = 0; prev_rdy = 0;
      if (done) begin
        chk(got == nb, "R10 words before done", 64'(got), 64'(nb));
        chk(req_ready, "R10 ready with done", 64'(req_ready), 64'(1));
        if (burst) begin
          for (int w = 0; w < 4; w++)
            chk(rd_data[w*32 +: 32] == mem({a[31:4], 2'(w), a[1:0]}), "R3 buffer slot",
                64'(rd_data[w*32 +: 32]), 64'(mem({a[31:4], 2'(w), a[1:0]})));
        end else begin
          chk(rd_data[a[3:2]*32 +: 32] == mem(a), "R4 single word slot",
              64'(rd_data[a[3:2]*32 +: 32]), 64'(mem(a)));
        end
        fin = 1;
      end else if (hold > 0) begin
        hold--;
        bus_backoff = (hold > 0);
        chk(!bus_oe, "R5 floated while backed off", 64'(bus_oe), 64'(0));
      end else if (bus_start) begin
        starts++;
        chk(bus_addr == word_addr(a, got), starts == 1 ? "R3 first address" : "R6 restart address",
            64'(bus_addr), 64'(word_addr(a, got)));
        chk(!req_ready, "R2 busy during transfer", 64'(req_ready), 64'(0));
        if (boffads && !ads_used) begin
          ads_used = 1; bus_backoff = 1'b1; hold = 2; prev_boff = 1; prev_ads = 1;
        end
      end else if (bus_oe) begin
        chk(bus_last == (got == nb - 1), "R8 last strobe", 64'(bus_last), 64'(got == nb - 1));
        if (got == boffw && !boff_used) begin
          boff_used = 1; bus_backoff = 1'b1; bus_brdy = 1'b1; hold = 2; prev_boff = 1;
        end else if (got == rdyw) begin
          bus_rdy = 1'b1; bus_data_in = mem(word_addr(a, got)); got++;
          prev_rdy = (got < nb);
        end else begin
          bus_brdy = 1'b1; bus_data_in = mem(word_addr(a, got)); got++;
        end
      end else begin
        chk(0, "R2 bus dropped mid transfer", 64'(bus_oe), 64'(1));
      end
      @(negedge clk);
    end
    bus_brdy = 1'b0; bus_rdy = 1'b0; bus_backoff = 1'b0;
    chk(fin, "R10 transfer completes", 64'(fin), 64'(1));
    chk(!done, "R10 done lasts one clock", 64'(done), 64'(0));
    chk(starts == exp_starts, "R9 start strobe count", 64'(starts), 64'(exp_starts));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state after reset
    chk(!bus_oe && !bus_start && !bus_last && !done, "R1 outputs quiet in reset",
        64'({bus_oe, bus_start, bus_last, done}), 64'(0));
    chk(req_ready, "R1 ready after reset", 64'(req_ready), 64'(1));
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      logic [42:0] e;
      e = VEC[v];
      run_txn(e[42:11], e[10], int'(e[9:7]), e[6], int'(e[5:3]), int'(e[2:0]));
    end

    // R1 reset in the middle of a burst data phase
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h6000_0000; req_burst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(bus_oe && !bus_start, "R2 waiting in data phase", 64'({bus_oe, bus_start}), 64'(2));
    rst = 1'b1;
    @(negedge clk);
    chk(!bus_oe && !bus_start && !bus_last && !done, "R1 reset mid transfer",
        64'({bus_oe, bus_start, bus_last, done}), 64'(0));
    chk(req_ready, "R1 ready after mid transfer reset", 64'(req_ready), 64'(1));
    rst = 1'b0;
    @(negedge clk);
    run_txn(32'h6000_0004, 1'b1, 1, 1'b0, 7, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule